// File: doc/BRIEF.md
# Aliased Register File with Unaligned Word Pairs

This block is the architectural register store of a 36-bit processor datapath. It presents three register name spaces, namely index, arithmetic and scratch, each with sixteen names. The top four index names and the bottom four arithmetic names land on the same physical words, so 44 words of storage back 48 names. An address calculation can then work on a value the arithmetic units just produced, with no copy between the two spaces.

Two read ports and one write port each take a group code, a register number and a pair flag. With the pair flag set, an access covers two neighbouring arithmetic registers as one 72-bit value, and it may begin at any register, odd or even. Two scratch registers are also wired straight out to the rest of the datapath. One holds the repeat count for repeatable operations and can be counted down by a strobe. The other holds a bit mask for masked logical operations.

Top module: `aliased_regfile`

## Requirements
- R1: After reset every register reads as zero, `rpt_count` and `bit_mask` are zero and `rpt_zero` is 1.
- R2: A single write stores `wr_data[35:0]` in the addressed register, using group code 0 for index, 1 for arithmetic and 2 for scratch. From the next cycle a single read of that register returns the word in `data[35:0]`, with `data[71:36]` zero.
- R3: Index registers 12 to 15 and arithmetic registers 0 to 3 are the same four words, index 12+k matching arithmetic k. A write through either name is visible through both names on the next cycle. Index 11 and arithmetic 4 are separate words.
- R4: A pair access at arithmetic register n, for any n from 0 to 14 including odd n, puts register n in bits 71:36 and register n+1 in bits 35:0 for both reads and writes. A pair may span the aliased boundary.
- R5: A pair access starting at arithmetic register 15, or a pair access in the index or scratch group, is rejected. A rejected read raises its error output and returns all zeros. A rejected write raises `wr_err` and changes no register.
- R6: When a read and the write address the same word in one cycle, the read returns the old value. The new value appears on the following cycle.
- R7: The two read ports work independently and can address different registers in the same cycle.
- R8: Scratch register 1 is driven continuously on `rpt_count`, and scratch register 2 on `bit_mask`. Both follow writes from the next cycle.
- R9: `rpt_dec` lowers a non-zero repeat count by one on the next cycle, and a count of zero stays at zero. A write to scratch 1 in the same cycle takes priority over the strobe. `rpt_zero` is 1 exactly when the count is zero.
- R10: Group code 3 is invalid. An access with this code raises the port's error output, reads return zero, and a write is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd0_grp | input | 2 | Read port 0 group code |
| rd0_idx | input | 4 | Read port 0 register number |
| rd0_dbl | input | 1 | Read port 0 pair access |
| rd0_data | output | 72 | Read port 0 data |
| rd0_err | output | 1 | Read port 0 rejected access |
| rd1_grp | input | 2 | Read port 1 group code |
| rd1_idx | input | 4 | Read port 1 register number |
| rd1_dbl | input | 1 | Read port 1 pair access |
| rd1_data | output | 72 | Read port 1 data |
| rd1_err | output | 1 | Read port 1 rejected access |
| wr_en | input | 1 | Write enable |
| wr_grp | input | 2 | Write group code |
| wr_idx | input | 4 | Write register number |
| wr_dbl | input | 1 | Pair write |
| wr_data | input | 72 | Write data |
| wr_err | output | 1 | Rejected write |
| rpt_dec | input | 1 | Repeat count decrement strobe |
| rpt_count | output | 36 | Repeat count (scratch 1) |
| rpt_zero | output | 1 | Repeat count is zero |
| bit_mask | output | 36 | Bit mask (scratch 2) |

## Verification
The bench uses the default parameters: 36-bit words, sixteen names per group and four shared words. With these values both ends of the overlap can be reached: index 11 against 12, and arithmetic 3 against 4. So can the rejected pair at register 15 and the odd-start pairs. The decrement tests go all the way down to zero and one step past it, which covers the floor case and a write arriving in the same cycle as the strobe.

// File: rtl/rfp_pkg.sv
package rfp_pkg;
    typedef enum logic [1:0] {
        GRP_IDX   = 2'd0,
        GRP_ARITH = 2'd1,
        GRP_SCR   = 2'd2,
        GRP_BAD   = 2'd3
    } grp_e;
endpackage

// File: rtl/rf_addr_map.sv
module rf_addr_map #(
    parameter int NUM_REG = 16,
    parameter int SHARED  = 4,
    parameter int IDX_W   = $clog2(NUM_REG),
    parameter int PHYS    = 3 * NUM_REG - SHARED,
    parameter int PHYS_W  = $clog2(PHYS + 1)
) (
    input  logic [1:0]        grp,
    input  logic [IDX_W-1:0]  idx,
    input  logic              dbl,
    output logic [PHYS_W-1:0] phys_hi,
    output logic [PHYS_W-1:0] phys_lo,
    output logic              err
);
    import rfp_pkg::*;

    localparam int ARITH_BASE = NUM_REG - SHARED;
    localparam int SCR_BASE   = 2 * NUM_REG - SHARED;

    grp_e g;
    int   base;

    always_comb begin
        g    = grp_e'(grp);
        base = 0;
        err  = 1'b0;
        unique case (g)
            GRP_IDX:   base = 0;
            GRP_ARITH: base = ARITH_BASE;
            GRP_SCR:   base = SCR_BASE;
            default:   err  = 1'b1;
        endcase
        if (dbl && (g != GRP_ARITH || int'(idx) == NUM_REG - 1))
            err = 1'b1;
        phys_hi = PHYS_W'(base + int'(idx));
        phys_lo = PHYS_W'(base + int'(idx) + 1);
    end
endmodule

// File: rtl/rf_store.sv
module rf_store #(
    parameter int WORD_W    = 36,
    parameter int PHYS      = 44,
    parameter int PHYS_W    = 6,
    parameter int RPT_PHYS  = 29,
    parameter int MASK_PHYS = 30
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_hi,
    input  logic [PHYS_W-1:0] addr_hi,
    input  logic [WORD_W-1:0] data_hi,
    input  logic              we_lo,
    input  logic [PHYS_W-1:0] addr_lo,
    input  logic [WORD_W-1:0] data_lo,
    input  logic              rpt_dec,
    output logic [WORD_W-1:0] word_o [PHYS]
);
    typedef struct {
        logic [WORD_W-1:0] word [PHYS];
    } state_t;

    state_t state_d, state_q;
    logic   rpt_hit;
    logic [WORD_W-1:0] rpt_q;

    assign rpt_q = state_q.word[RPT_PHYS];

    always_comb begin
        state_d = state_q;
        rpt_hit = (we_hi && int'(addr_hi) == RPT_PHYS)
               || (we_lo && int'(addr_lo) == RPT_PHYS);
        if (rpt_dec && !rpt_hit && rpt_q != '0)
            state_d.word[RPT_PHYS] = rpt_q - WORD_W'(1);
        if (we_hi) state_d.word[addr_hi] = data_hi;
        if (we_lo) state_d.word[addr_lo] = data_lo;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < PHYS; i++) state_q.word[i] <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign word_o = state_q.word;

    // R2: an accepted write is present in storage on the next cycle
    assert_write_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
        we_hi |=> state_q.word[$past(addr_hi)] == $past(data_hi));

    // R9: a strobe lowers a non-zero count by exactly one
    assert_dec_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rpt_dec && !rpt_hit && rpt_q != '0) |=> rpt_q == $past(rpt_q) - WORD_W'(1));

    // R9: the count does not wrap below zero
    assert_dec_floor_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rpt_dec && !rpt_hit && rpt_q == '0) |=> rpt_q == '0);

    // R9: write to the count register overrides the strobe
    assert_write_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rpt_dec && we_hi && int'(addr_hi) == RPT_PHYS) |=> rpt_q == $past(data_hi));
endmodule

// File: rtl/aliased_regfile.sv
module aliased_regfile #(
    parameter int WORD_W  = 36,
    parameter int NUM_REG = 16,
    parameter int SHARED  = 4,
    parameter int IDX_W   = $clog2(NUM_REG)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [1:0]          rd0_grp,
    input  logic [IDX_W-1:0]    rd0_idx,
    input  logic                rd0_dbl,
    output logic [2*WORD_W-1:0] rd0_data,
    output logic                rd0_err,
    input  logic [1:0]          rd1_grp,
    input  logic [IDX_W-1:0]    rd1_idx,
    input  logic                rd1_dbl,
    output logic [2*WORD_W-1:0] rd1_data,
    output logic                rd1_err,
    input  logic                wr_en,
    input  logic [1:0]          wr_grp,
    input  logic [IDX_W-1:0]    wr_idx,
    input  logic                wr_dbl,
    input  logic [2*WORD_W-1:0] wr_data,
    output logic                wr_err,
    input  logic                rpt_dec,
    output logic [WORD_W-1:0]   rpt_count,
    output logic                rpt_zero,
    output logic [WORD_W-1:0]   bit_mask
);
    localparam int PHYS      = 3 * NUM_REG - SHARED;
    localparam int PHYS_W    = $clog2(PHYS + 1);
    localparam int SCR_BASE  = 2 * NUM_REG - SHARED;
    localparam int RPT_PHYS  = SCR_BASE + 1;
    localparam int MASK_PHYS = SCR_BASE + 2;
    localparam int NUM_RD    = 2;

    logic [WORD_W-1:0] word [PHYS];

    // read-port bundles
    logic [1:0]          rp_grp  [NUM_RD];
    logic [IDX_W-1:0]    rp_idx  [NUM_RD];
    logic                rp_dbl  [NUM_RD];
    logic [2*WORD_W-1:0] rp_data [NUM_RD];
    logic                rp_err  [NUM_RD];

    assign rp_grp[0] = rd0_grp;
    assign rp_idx[0] = rd0_idx;
    assign rp_dbl[0] = rd0_dbl;
    assign rp_grp[1] = rd1_grp;
    assign rp_idx[1] = rd1_idx;
    assign rp_dbl[1] = rd1_dbl;
    assign rd0_data  = rp_data[0];
    assign rd0_err   = rp_err[0];
    assign rd1_data  = rp_data[1];
    assign rd1_err   = rp_err[1];

    for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
        logic [PHYS_W-1:0] a_hi, a_lo;
        logic              bad;

        rf_addr_map #(
            .NUM_REG(NUM_REG), .SHARED(SHARED), .IDX_W(IDX_W),
            .PHYS(PHYS), .PHYS_W(PHYS_W)
        ) u_map (
            .grp(rp_grp[p]), .idx(rp_idx[p]), .dbl(rp_dbl[p]),
            .phys_hi(a_hi), .phys_lo(a_lo), .err(bad)
        );

        always_comb begin
            rp_err[p]  = bad;
            rp_data[p] = '0;
            if (!bad) begin
                if (rp_dbl[p]) rp_data[p] = {word[a_hi], word[a_lo]};
                else           rp_data[p] = {{WORD_W{1'b0}}, word[a_hi]};
            end
        end

        // R5: a pair starting at the last arithmetic register is refused
        assert_pair_reject_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (rp_dbl[p] && rp_grp[p] == 2'd1 && int'(rp_idx[p]) == NUM_REG - 1) |-> rp_err[p]);

        // R5 / R10: a refused read returns nothing
        assert_err_blank_R5: assert property (@(posedge clk) disable iff (!rst_n)
            rp_err[p] |-> rp_data[p] == '0);
    end

    // write path
    logic [PHYS_W-1:0] w_hi, w_lo;
    logic              w_bad;

    rf_addr_map #(
        .NUM_REG(NUM_REG), .SHARED(SHARED), .IDX_W(IDX_W),
        .PHYS(PHYS), .PHYS_W(PHYS_W)
    ) u_wmap (
        .grp(wr_grp), .idx(wr_idx), .dbl(wr_dbl),
        .phys_hi(w_hi), .phys_lo(w_lo), .err(w_bad)
    );

    logic              we_hi, we_lo;
    logic [WORD_W-1:0] wd_hi;

    always_comb begin
        wr_err = wr_en && w_bad;
        we_hi  = wr_en && !w_bad;
        we_lo  = wr_en && !w_bad && wr_dbl;
        wd_hi  = wr_dbl ? wr_data[2*WORD_W-1:WORD_W] : wr_data[WORD_W-1:0];
    end

    rf_store #(
        .WORD_W(WORD_W), .PHYS(PHYS), .PHYS_W(PHYS_W),
        .RPT_PHYS(RPT_PHYS), .MASK_PHYS(MASK_PHYS)
    ) u_store (
        .clk(clk), .rst_n(rst_n),
        .we_hi(we_hi), .addr_hi(w_hi), .data_hi(wd_hi),
        .we_lo(we_lo), .addr_lo(w_lo), .data_lo(wr_data[WORD_W-1:0]),
        .rpt_dec(rpt_dec), .word_o(word)
    );

    assign rpt_count = word[RPT_PHYS];
    assign bit_mask  = word[MASK_PHYS];
    assign rpt_zero  = (rpt_count == '0);

    // R10: an invalid-group write leaves the dedicated outputs untouched
    assert_bad_write_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_grp == 2'd3 && !rpt_dec) |=> ($stable(rpt_count) && $stable(bit_mask)));

    // R10: group code 3 is always flagged on the write port
    assert_bad_group_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_grp == 2'd3) |-> wr_err);
endmodule

// File: tb/aliased_regfile_tb.sv
module aliased_regfile_tb;
    localparam int W = 36;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic          rst_n;
    logic [1:0]    rd0_grp, rd1_grp, wr_grp;
    logic [3:0]    rd0_idx, rd1_idx, wr_idx;
    logic          rd0_dbl, rd1_dbl, wr_dbl, wr_en, rpt_dec;
    logic [2*W-1:0] rd0_data, rd1_data, wr_data;
    logic          rd0_err, rd1_err, wr_err, rpt_zero;
    logic [W-1:0]  rpt_count, bit_mask;

    int n_cmp = 0;
    int n_bad = 0;

    aliased_regfile u_dut (
        .clk(clk), .rst_n(rst_n),
        .rd0_grp(rd0_grp), .rd0_idx(rd0_idx), .rd0_dbl(rd0_dbl),
        .rd0_data(rd0_data), .rd0_err(rd0_err),
        .rd1_grp(rd1_grp), .rd1_idx(rd1_idx), .rd1_dbl(rd1_dbl),
        .rd1_data(rd1_data), .rd1_err(rd1_err),
        .wr_en(wr_en), .wr_grp(wr_grp), .wr_idx(wr_idx), .wr_dbl(wr_dbl),
        .wr_data(wr_data), .wr_err(wr_err),
        .rpt_dec(rpt_dec), .rpt_count(rpt_count), .rpt_zero(rpt_zero),
        .bit_mask(bit_mask)
    );

    task automatic chk(string req, logic [2*W-1:0] act, logic [2*W-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(logic [1:0] g, logic [3:0] i, logic d, logic [2*W-1:0] v);
        @(negedge clk);
        wr_en = 1'b1; wr_grp = g; wr_idx = i; wr_dbl = d; wr_data = v;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd0(logic [1:0] g, logic [3:0] i, logic d);
        rd0_grp = g; rd0_idx = i; rd0_dbl = d;
        #1;
    endtask

    task automatic t_reset();
        @(negedge clk);
        rd0(2'd0, 4'd0, 1'b0);  chk("R1 idx0", rd0_data, '0);
        rd0(2'd1, 4'd15, 1'b0); chk("R1 arith15", rd0_data, '0);
        chk("R1 count", {36'd0, rpt_count}, '0);
        chk("R1 mask", {36'd0, bit_mask}, '0);
        chk("R1 zero flag", {71'd0, rpt_zero}, 72'd1);
    endtask

    task automatic t_single();
        wr(2'd0, 4'd5, 1'b0, {36'hFFFFFFFFF, 36'h0000A0005});
        wr(2'd1, 4'd9, 1'b0, {36'd0, 36'h0000B0009});
        wr(2'd2, 4'd7, 1'b0, {36'd0, 36'h0000C0007});
        rd0(2'd0, 4'd5, 1'b0); chk("R2 idx5", rd0_data, {36'd0, 36'h0000A0005});
        rd0(2'd1, 4'd9, 1'b0); chk("R2 arith9", rd0_data, {36'd0, 36'h0000B0009});
        rd0(2'd2, 4'd7, 1'b0); chk("R2 scr7", rd0_data, {36'd0, 36'h0000C0007});
        // R7: both ports at once, different registers
        rd0(2'd0, 4'd5, 1'b0);
        rd1_grp = 2'd1; rd1_idx = 4'd9; rd1_dbl = 1'b0; #1;
        chk("R7 port0", rd0_data, {36'd0, 36'h0000A0005});
        chk("R7 port1", rd1_data, {36'd0, 36'h0000B0009});
    endtask

    task automatic t_alias();
        wr(2'd0, 4'd13, 1'b0, {36'd0, 36'h13131313D});
        rd0(2'd1, 4'd1, 1'b0); chk("R3 idx13 via arith1", rd0_data, {36'd0, 36'h13131313D});
        wr(2'd1, 4'd3, 1'b0, {36'd0, 36'h30303030F});
        rd0(2'd0, 4'd15, 1'b0); chk("R3 arith3 via idx15", rd0_data, {36'd0, 36'h30303030F});
        wr(2'd0, 4'd11, 1'b0, {36'd0, 36'h00000011B});
        rd0(2'd1, 4'd4, 1'b0); chk("R3 arith4 separate", rd0_data, '0);
        rd0(2'd0, 4'd12, 1'b0); chk("R3 idx12 separate from idx11", rd0_data, '0);
    endtask

    task automatic t_pair();
        wr(2'd1, 4'd5, 1'b1, {36'h123456789, 36'hABCDEF012});
        rd0(2'd1, 4'd5, 1'b0); chk("R4 odd pair hi", rd0_data, {36'd0, 36'h123456789});
        rd0(2'd1, 4'd6, 1'b0); chk("R4 odd pair lo", rd0_data, {36'd0, 36'hABCDEF012});
        rd0(2'd1, 4'd5, 1'b1); chk("R4 pair read", rd0_data, {36'h123456789, 36'hABCDEF012});
        wr(2'd1, 4'd3, 1'b1, {36'h333333333, 36'h444444444});
        rd0(2'd0, 4'd15, 1'b0); chk("R4 boundary hi via idx15", rd0_data, {36'd0, 36'h333333333});
        rd0(2'd1, 4'd4, 1'b0); chk("R4 boundary lo", rd0_data, {36'd0, 36'h444444444});
        rd0(2'd1, 4'd14, 1'b1); chk("R4 pair at 14", rd0_data, '0);
    endtask

    task automatic t_reject();
        rd0(2'd1, 4'd15, 1'b1);
        chk("R5 pair@15 err", {71'd0, rd0_err}, 72'd1);
        chk("R5 pair@15 data", rd0_data, '0);
        rd0(2'd0, 4'd3, 1'b1);
        chk("R5 index pair err", {71'd0, rd0_err}, 72'd1);
        @(negedge clk);
        wr_en = 1'b1; wr_grp = 2'd1; wr_idx = 4'd15; wr_dbl = 1'b1;
        wr_data = {36'h555555555, 36'h666666666}; #1;
        chk("R5 write flag", {71'd0, wr_err}, 72'd1);
        @(negedge clk); wr_en = 1'b0;
        rd0(2'd1, 4'd15, 1'b0); chk("R5 arith15 untouched", rd0_data, '0);
        rd0(2'd2, 4'd0, 1'b0); chk("R5 scr0 untouched", rd0_data, '0);
        rd0(2'd3, 4'd0, 1'b0);
        chk("R10 read err", {71'd0, rd0_err}, 72'd1);
        chk("R10 read data", rd0_data, '0);
        @(negedge clk);
        wr_en = 1'b1; wr_grp = 2'd3; wr_idx = 4'd1; wr_dbl = 1'b0;
        wr_data = {36'd0, 36'h777777777}; #1;
        chk("R10 write flag", {71'd0, wr_err}, 72'd1);
        @(negedge clk); wr_en = 1'b0; #1;
        chk("R10 count unchanged", {36'd0, rpt_count}, '0);
        rd0(2'd0, 4'd1, 1'b0); chk("R10 idx1 unchanged", rd0_data, '0);
    endtask

    task automatic t_same_cycle();
        wr(2'd1, 4'd8, 1'b0, {36'd0, 36'h000000008});
        @(negedge clk);
        wr_en = 1'b1; wr_grp = 2'd1; wr_idx = 4'd8; wr_dbl = 1'b0;
        wr_data = {36'd0, 36'h888888888};
        rd0(2'd1, 4'd8, 1'b0);
        chk("R6 old value", rd0_data, {36'd0, 36'h000000008});
        @(negedge clk); wr_en = 1'b0; #1;
        chk("R6 new value", rd0_data, {36'd0, 36'h888888888});
    endtask

    task automatic t_repeat();
        wr(2'd2, 4'd2, 1'b0, {36'd0, 36'hF0F0F0F0F});
        chk("R8 mask", {36'd0, bit_mask}, {36'd0, 36'hF0F0F0F0F});
        wr(2'd2, 4'd1, 1'b0, {36'd0, 36'd3});
        chk("R8 count", {36'd0, rpt_count}, 72'd3);
        chk("R9 nonzero flag", {71'd0, rpt_zero}, 72'd0);
        @(negedge clk); rpt_dec = 1'b1;
        @(negedge clk); #1; chk("R9 step 2", {36'd0, rpt_count}, 72'd2);
        @(negedge clk); #1; chk("R9 step 1", {36'd0, rpt_count}, 72'd1);
        @(negedge clk); #1; chk("R9 step 0", {36'd0, rpt_count}, 72'd0);
        chk("R9 zero flag", {71'd0, rpt_zero}, 72'd1);
        @(negedge clk); #1; chk("R9 floor", {36'd0, rpt_count}, 72'd0);
        @(negedge clk);
        wr_en = 1'b1; wr_grp = 2'd2; wr_idx = 4'd1; wr_dbl = 1'b0;
        wr_data = {36'd0, 36'd5};
        @(negedge clk); wr_en = 1'b0; rpt_dec = 1'b0; #1;
        chk("R9 write over strobe", {36'd0, rpt_count}, 72'd5);
        chk("R8 mask kept", {36'd0, bit_mask}, {36'd0, 36'hF0F0F0F0F});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; wr_en = 1'b0; wr_grp = '0; wr_idx = '0; wr_dbl = 1'b0;
        wr_data = '0; rpt_dec = 1'b0;
        rd0_grp = '0; rd0_idx = '0; rd0_dbl = 1'b0;
        rd1_grp = '0; rd1_idx = '0; rd1_dbl = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_single();
        t_alias();
        t_pair();
        t_reject();
        t_same_cycle();
        t_repeat();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule